// File: doc/BRIEF.md
# Prefetch Request Source Arbiter

This block sits in front of an instruction prefetch pipeline and chooses, each cycle, at most one prefetch request to hand downstream over a valid/ready handshake. Requests come from two kinds of source. Several load ports may each raise a software prefetch hint carrying a virtual address. A single fetch-directed hardware stream supplies prefetch requests that may cover one or two fetch blocks.

Software hints are best-effort. When several load ports fire in the same cycle, only the lowest-numbered one is kept and the rest are dropped. The kept hint goes into a one-entry holding slot. A newer hint replaces whatever the slot holds, even when that entry is stalled waiting for the downstream stage. A held hint always goes downstream ahead of the hardware stream. Each issued request carries a flag that tells the next stage whether to record way-lookup metadata. The flag is set for hardware requests and clear for software hints. A flush empties the slot and shuts both sources out for as long as it lasts.

Top module: `pf_source_arb`

## Requirements
- R1: After reset the holding slot is empty: with the hardware source valid and downstream ready, the issued request is the hardware one (out_wr_meta = 1, out_va = hw_va).
- R2: When several load ports raise sw_vld in the same cycle, only the port with the lowest index is captured, and the other ports' addresses are never issued.
- R3: A software hint arriving while the slot is occupied replaces the held entry, even while downstream is stalled. The replaced entry is never issued.
- R4: While the slot is occupied, the slot's entry is presented downstream and hw_rdy is 0. While the slot is empty, hw_rdy = out_rdy and not flush.
- R5: A software hint is always issued with out_dual = 0. A hardware request is issued with out_dual equal to hw_dual.
- R6: out_wr_meta is 0 when the issued request comes from the slot and 1 when it comes from the hardware source.
- R7: While flush is 1, out_vld, hw_rdy and sw_rdy are all 0, and software hints raised in that cycle are not captured.
- R8: A flush empties the holding slot: a hint held before the flush is never issued after it.
- R9: A captured hint is presented in the cycle after capture and stays presented, unchanged, until out_rdy accepts it or it is replaced or flushed. After acceptance the slot is empty unless a new hint arrived in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Flush in progress; blocks both sources and empties the slot |
| sw_vld | input | N_LDU | Software hint valid, one bit per load port |
| sw_va | input | N_LDU*VA_W | Software hint addresses; port i uses bits [i*VA_W +: VA_W] |
| sw_rdy | output | 1 | Software hints can be taken (low during flush) |
| hw_vld | input | 1 | Hardware prefetch valid |
| hw_va | input | VA_W | Hardware prefetch address |
| hw_dual | input | 1 | Hardware request covers two fetch blocks |
| hw_rdy | output | 1 | Hardware request accepted this cycle when hw_vld is 1 |
| out_vld | output | 1 | Request presented downstream |
| out_rdy | input | 1 | Downstream takes the request |
| out_va | output | VA_W | Issued address |
| out_dual | output | 1 | Issued request covers two fetch blocks |
| out_wr_meta | output | 1 | Downstream should record way-lookup metadata |

## Verification
The bench runs a scoreboard model of the slot against a stimulus table. The table includes three-way simultaneous hints, which would expose a design that picks the highest port or merges addresses. It includes a hint landing on a stalled slot, where a design that refuses to overwrite would issue the stale address. It also includes hardware and software requests that collide, where a wrong design would let the hardware request through or assert hw_rdy while the slot is held. Flushes are applied both with a hint arriving and with a hint already held, to catch a slot that survives the flush or captures during it. The dual flag on software issues and the drop count over the whole run are compared with the model.

// File: rtl/pf_arb_pkg.sv
package pf_arb_pkg;

  // index of the least significant set bit, or 0 when none is set
  function automatic int unsigned first_set(input logic [31:0] v);
    int unsigned idx;
    idx = 0;
    for (int i = 31; i >= 0; i--) begin
      if (v[i]) idx = i;
    end
    return idx;
  endfunction

  // issue source encoding
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_SW   = 2'd1,
    SRC_HW   = 2'd2
  } pf_src_e;

endpackage

// File: rtl/pf_lowest_pick.sv
module pf_lowest_pick #(
  parameter int N_LDU = 3,
  parameter int VA_W  = 50
) (
  input  logic [N_LDU-1:0]      req,
  input  logic [N_LDU*VA_W-1:0] va_flat,
  output logic                  any,
  output logic [VA_W-1:0]       va_sel
);
  import pf_arb_pkg::*;

  localparam int PAD_W = 32 - N_LDU;

  logic [31:0] req_w;
  int unsigned win;

  assign req_w = {{PAD_W{1'b0}}, req};
  assign any   = |req;

  always_comb begin
    win    = first_set(req_w);
    va_sel = '0;
    for (int i = 0; i < N_LDU; i++) begin
      if (win == i) va_sel = va_flat[i*VA_W +: VA_W];
    end
  end
endmodule

// File: rtl/pf_sw_slot.sv
module pf_sw_slot #(
  parameter int VA_W = 50
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush,
  input  logic            load,
  input  logic [VA_W-1:0] load_va,
  input  logic            drain,
  output logic            slot_vld,
  output logic [VA_W-1:0] slot_va
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_vld <= 1'b0;
      slot_va  <= '0;
    end else if (flush) begin
      slot_vld <= 1'b0;
    end else if (load) begin
      slot_vld <= 1'b1;
      slot_va  <= load_va;
    end else if (drain) begin
      slot_vld <= 1'b0;
    end
  end
endmodule

// File: rtl/pf_issue_mux.sv
module pf_issue_mux #(
  parameter int VA_W = 50
) (
  input  logic            flush,
  input  logic            slot_vld,
  input  logic [VA_W-1:0] slot_va,
  input  logic            hw_vld,
  input  logic [VA_W-1:0] hw_va,
  input  logic            hw_dual,
  input  logic            out_rdy,
  output logic            hw_rdy,
  output logic            out_vld,
  output logic [VA_W-1:0] out_va,
  output logic            out_dual,
  output logic            out_wr_meta,
  output logic            sw_fire
);
  import pf_arb_pkg::*;

  pf_src_e src;

  always_comb begin
    if (flush)         src = SRC_NONE;
    else if (slot_vld) src = SRC_SW;
    else if (hw_vld)   src = SRC_HW;
    else               src = SRC_NONE;
  end

  assign out_vld     = (src != SRC_NONE);
  assign out_va      = (src == SRC_SW) ? slot_va : hw_va;
  assign out_dual    = (src == SRC_HW) && hw_dual;
  assign out_wr_meta = (src != SRC_SW);
  assign hw_rdy      = !flush && !slot_vld && out_rdy;
  assign sw_fire     = (src == SRC_SW) && out_rdy;
endmodule

// File: rtl/pf_source_arb.sv
module pf_source_arb #(
  parameter int N_LDU = 3,
  parameter int VA_W  = 50
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  flush,
  input  logic [N_LDU-1:0]      sw_vld,
  input  logic [N_LDU*VA_W-1:0] sw_va,
  output logic                  sw_rdy,
  input  logic                  hw_vld,
  input  logic [VA_W-1:0]       hw_va,
  input  logic                  hw_dual,
  output logic                  hw_rdy,
  output logic                  out_vld,
  input  logic                  out_rdy,
  output logic [VA_W-1:0]       out_va,
  output logic                  out_dual,
  output logic                  out_wr_meta
);
  // named internal events, used by the bound checker
  logic            sw_any;
  logic [VA_W-1:0] sw_pick_va;
  logic            sw_load;
  logic            slot_vld;
  logic [VA_W-1:0] slot_va;
  logic            sw_fire;

  assign sw_rdy  = !flush;
  assign sw_load = sw_any && !flush;

  pf_lowest_pick #(.N_LDU(N_LDU), .VA_W(VA_W)) u_pick (
    .req     (sw_vld),
    .va_flat (sw_va),
    .any     (sw_any),
    .va_sel  (sw_pick_va)
  );

  pf_sw_slot #(.VA_W(VA_W)) u_slot (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .load     (sw_load),
    .load_va  (sw_pick_va),
    .drain    (sw_fire),
    .slot_vld (slot_vld),
    .slot_va  (slot_va)
  );

  pf_issue_mux #(.VA_W(VA_W)) u_mux (
    .flush       (flush),
    .slot_vld    (slot_vld),
    .slot_va     (slot_va),
    .hw_vld      (hw_vld),
    .hw_va       (hw_va),
    .hw_dual     (hw_dual),
    .out_rdy     (out_rdy),
    .hw_rdy      (hw_rdy),
    .out_vld     (out_vld),
    .out_va      (out_va),
    .out_dual    (out_dual),
    .out_wr_meta (out_wr_meta),
    .sw_fire     (sw_fire)
  );
endmodule

// File: rtl/pf_source_arb_chk.sv
module pf_source_arb_chk #(
  parameter int N_LDU = 3,
  parameter int VA_W  = 50
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  flush,
  input logic [N_LDU-1:0]      sw_vld,
  input logic                  sw_rdy,
  input logic                  hw_vld,
  input logic                  hw_rdy,
  input logic                  out_vld,
  input logic                  out_rdy,
  input logic [VA_W-1:0]       out_va,
  input logic                  out_dual,
  input logic                  out_wr_meta,
  input logic                  sw_any,
  input logic                  slot_vld,
  input logic [VA_W-1:0]       slot_va
);
  p_flush_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (!out_vld && !hw_rdy && !sw_rdy));

  p_flush_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !slot_vld);

  p_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_any && !flush) |=> slot_vld);

  p_hw_held_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    slot_vld |-> !hw_rdy);

  p_sw_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && !out_wr_meta) |-> !out_dual);

  p_sw_no_meta_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && slot_vld) |-> (!out_wr_meta && out_va == slot_va));

  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_vld && !out_rdy && !sw_any && !flush) |=> (slot_vld && $stable(slot_va)));
endmodule

bind pf_source_arb pf_source_arb_chk #(.N_LDU(N_LDU), .VA_W(VA_W)) u_chk (.*);

// File: tb/sim_pf_source_arb.sv
module sim_pf_source_arb;
  localparam int N  = 3;
  localparam int VW = 50;
  localparam int NV = 16;

  // vector bits: [6] flush, [5] out_rdy, [4] hw_dual, [3] hw_vld, [2:0] sw_vld
  localparam logic [6:0] VEC [NV] = '{
    7'b0_1_0_1_000, 7'b0_1_1_1_110, 7'b0_0_0_1_000, 7'b0_0_0_1_100,
    7'b0_1_0_1_000, 7'b0_1_1_1_000, 7'b0_1_0_0_111, 7'b1_1_0_1_001,
    7'b0_1_0_1_000, 7'b0_1_0_0_011, 7'b0_1_0_0_010, 7'b0_1_0_0_000,
    7'b0_1_0_0_000, 7'b0_0_0_0_100, 7'b1_0_0_1_000, 7'b0_1_0_1_000
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 1'b0;
  logic [N-1:0] sw_vld = '0;
  logic [N*VW-1:0] sw_va = '0;
  logic sw_rdy, hw_rdy, out_vld, out_dual, out_wr_meta;
  logic hw_vld = 1'b0, hw_dual = 1'b0, out_rdy = 1'b0;
  logic [VW-1:0] hw_va = '0;
  logic [VW-1:0] out_va;

  int checks = 0, fails = 0;
  bit done = 0;
  // scoreboard model
  bit m_vld = 0;
  logic [VW-1:0] m_va = '0;
  int sw_issued = 0, m_sw_issued = 0;

  always #4 clk = ~clk;

  pf_source_arb #(.N_LDU(N), .VA_W(VW)) u0 (
    .clk(clk), .rst_n(rst_n), .flush(flush), .sw_vld(sw_vld), .sw_va(sw_va),
    .sw_rdy(sw_rdy), .hw_vld(hw_vld), .hw_va(hw_va), .hw_dual(hw_dual),
    .hw_rdy(hw_rdy), .out_vld(out_vld), .out_rdy(out_rdy), .out_va(out_va),
    .out_dual(out_dual), .out_wr_meta(out_wr_meta)
  );

  task automatic chk(input string req, input string what, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [VW-1:0] swaddr(input int step, input int port);
    return VW'((step << 8) | ((port + 1) << 4));
  endfunction

  // drive one cycle, compare against the model, then advance the model
  task automatic step(input int s, input logic [6:0] v);
    logic [VW-1:0] pick;
    bit got;
    bit e_vld, e_sw;
    @(negedge clk);
    flush = v[6]; out_rdy = v[5]; hw_dual = v[4]; hw_vld = v[3]; sw_vld = v[2:0];
    for (int p = 0; p < N; p++) sw_va[p*VW +: VW] = swaddr(s, p);
    hw_va = VW'((s << 8) | 8'hF0);
    #3;
    e_sw  = !flush && m_vld;
    e_vld = !flush && (m_vld || hw_vld);
    chk("R9", "out_vld", VW'(out_vld), VW'(e_vld));
    chk("R4", "hw_rdy", VW'(hw_rdy), VW'(!flush && !m_vld && out_rdy));
    chk("R7", "sw_rdy", VW'(sw_rdy), VW'(!flush));
    if (e_vld) begin
      chk("R2", "out_va", out_va, e_sw ? m_va : hw_va);
      chk("R5", "out_dual", VW'(out_dual), VW'(!e_sw && hw_dual));
      chk("R6", "out_wr_meta", VW'(out_wr_meta), VW'(!e_sw));
    end
    if (out_vld && out_rdy && !out_wr_meta) sw_issued++;
    if (e_sw && out_rdy) m_sw_issued++;
    got = 0; pick = '0;
    for (int p = 0; p < N; p++) if (!got && sw_vld[p]) begin got = 1; pick = swaddr(s, p); end
    @(posedge clk);
    if (flush) m_vld = 0;
    else if (got) begin m_vld = 1; m_va = pick; end
    else if (m_vld && out_rdy) m_vld = 0;
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    #3;
    chk("R1", "out_vld in reset", VW'(out_vld), '0);
    rst_n = 1'b1;
    // R1: slot empty after reset, hardware passes through
    @(negedge clk);
    hw_vld = 1; out_rdy = 1; hw_va = 50'h123; hw_dual = 0;
    #3;
    chk("R1", "out_wr_meta", VW'(out_wr_meta), VW'(1));
    chk("R1", "out_va", out_va, 50'h123);
    @(posedge clk);

    for (int s = 0; s < NV; s++) step(s, VEC[s]);

    // R3: directed overwrite under stall
    step(100, 7'b0_0_0_1_010);
    step(101, 7'b0_0_0_1_001);
    @(negedge clk);
    sw_vld = 0; out_rdy = 0; flush = 0; #3;
    chk("R3", "overwritten va", out_va, swaddr(101, 0));
    @(posedge clk);
    // R8: directed flush while held, then hardware goes first
    step(102, 7'b1_0_0_0_000);
    @(negedge clk);
    hw_vld = 1; hw_va = 50'h777; out_rdy = 1; #3;
    chk("R8", "after flush source", VW'(out_wr_meta), VW'(1));
    chk("R8", "after flush va", out_va, 50'h777);
    @(posedge clk);

    // R2: drop count over the whole run
    chk("R2", "sw issued count", VW'(sw_issued), VW'(m_sw_issued));

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule